// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Arithmetic Slice

This block is a reconfigurable arithmetic datapath built around four W-bit multiplier lanes. A two-bit function select picks one of four operating modes per sample: a single product, a running multiply-accumulate, a two-product add/subtract, or a four-product add/subtract-sum. Signed or unsigned arithmetic and add or subtract are chosen per sample at runtime. All operands in one sample share the same signedness and the same width W, which is 9, 18 or 36.

Three register points can each be enabled by a parameter: the operand capture, the multiplier outputs and the final result. A valid flag travels through exactly the same registers as the data, so the result latency is the number of enabled register points. The A operand of each lane comes either from the parallel A bus or from a shift chain. In the shift chain, lane 0 takes the serial input, each higher lane takes the A operand that the lane below used on the previous valid sample, and the top lane's A operand leaves on a serial output toward the next slice.

The function select is held as an enumerated mode with four states: MULT, MAC, PAIR and QUAD. There are no autonomous transitions. Each valid sample carries its own mode through the pipeline, and that mode chooses the combine path at the last stage. The accumulator register changes only for valid samples in the MAC state.

Top module: `mac_slice`

## Requirements
- R1: After synchronous reset, out_valid is low, shift_out is zero and the accumulator holds zero, so a first MAC sample without clear returns just its own product.
- R2: Mode 0 (MULT) returns A0*B0 at full precision. The product is sign- or zero-extended to the 2W+16-bit result.
- R3: When is_signed is 1, every operand is two's complement. When it is 0, every operand is unsigned. This covers the most negative value, the all-ones value and zero.
- R4: Mode 2 (PAIR) returns A0*B0 + A1*B1 when sub_en is 0, and A0*B0 - A1*B1 when sub_en is 1.
- R5: Mode 3 (QUAD) returns (A0*B0 ± A1*B1) + (A2*B2 ± A3*B3). The same sub_en choice applies to both pairs.
- R6: Mode 1 (MAC) adds A0*B0 to a 2W+16-bit accumulator on each valid sample and returns the new total. The total may exceed the 2W+2-bit product range.
- R7: A MAC sample with acc_clr set loads the accumulator with its own product instead of adding to the old total.
- R8: Cycles with in_valid low, and valid samples in other modes, leave the accumulator unchanged.
- R9: out_valid and result appear exactly IN_REG+MID_REG+OUT_REG cycles after in_valid. With all three disabled, the path is combinational.
- R10: When shift_sel is 0, lane k's A operand is a_par[k*W +: W]. When shift_sel is 1, lane 0 uses shift_in and lane k uses the A operand that lane k-1 used on the previous valid sample. shift_out is lane 3's last A operand and holds while in_valid is low.
- R11: Mode, sign, subtract and clear are captured with each sample, so back-to-back samples with different settings each return their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on the inputs |
| mode | input | 2 | 0 MULT, 1 MAC, 2 PAIR, 3 QUAD |
| is_signed | input | 1 | 1 two's complement, 0 unsigned |
| sub_en | input | 1 | 1 subtract odd lanes in PAIR/QUAD |
| acc_clr | input | 1 | Restart accumulator with this product |
| shift_sel | input | 1 | A operands from shift chain |
| shift_in | input | W | Serial A operand from previous slice |
| a_par | input | 4*W | Parallel A operands, lane k at k*W |
| b_par | input | 4*W | B operands, lane k at k*W |
| result | output | 2*W+16 | Full-precision result |
| out_valid | output | 1 | result is valid |
| shift_out | output | W | Lane 3 A operand toward next slice |

## Verification
A corrupted accumulator is invisible in MULT, PAIR and QUAD. It shows up at the next MAC sample without clear, one pipeline latency after that sample is issued. After that it persists in every later MAC result until a clear. A wrong shift chain register shows on shift_out one cycle after the valid sample that loaded it. It also shows in the QUAD sum of the following shifted sample. A misaligned valid register shows as out_valid arriving one cycle early or late against the directed sample.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        MD_MULT = 2'd0,
        MD_MAC  = 2'd1,
        MD_PAIR = 2'd2,
        MD_QUAD = 2'd3
    } mac_mode_e;

    typedef struct packed {
        logic      vld;
        mac_mode_e mode;
        logic      sgn;
        logic      sub;
        logic      clr;
    } mac_ctl_t;

endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage
    import mac_slice_pkg::*;
#(
    parameter int W      = 18,
    parameter bit IN_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  mac_ctl_t           ctl_in,
    input  logic               shift_sel,
    input  logic [W-1:0]       shift_in,
    input  logic [LANES*W-1:0] a_par,
    input  logic [LANES*W-1:0] b_par,
    output mac_ctl_t           ctl_out,
    output logic [LANES*W-1:0] a_out,
    output logic [LANES*W-1:0] b_out,
    output logic [W-1:0]       shift_out
);

    localparam int VW = LANES * W;

    logic [VW-1:0] a_sel;
    logic [VW-1:0] chain_q;

    // lane A operand: parallel bus or the neighbour's last operand
    for (genvar k = 0; k < LANES; k++) begin : g_sel
        if (k == 0) begin : g_head
            assign a_sel[W-1:0] = shift_sel ? shift_in : a_par[W-1:0];
        end else begin : g_body
            assign a_sel[k*W +: W] = shift_sel ? chain_q[(k-1)*W +: W]
                                               : a_par[k*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (ctl_in.vld) begin
            chain_q <= a_sel;
        end
    end

    assign shift_out = chain_q[VW-1 -: W];

    if (IN_REG) begin : g_reg
        mac_ctl_t      ctl_q;
        logic [VW-1:0] a_q;
        logic [VW-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q <= '0;
                a_q   <= '0;
                b_q   <= '0;
            end else begin
                ctl_q <= ctl_in;
                a_q   <= a_sel;
                b_q   <= b_par;
            end
        end
        assign ctl_out = ctl_q;
        assign a_out   = a_q;
        assign b_out   = b_q;
    end else begin : g_pass
        assign ctl_out = ctl_in;
        assign a_out   = a_sel;
        assign b_out   = b_par;
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl_in.vld |=> $stable(shift_out)); // R10

endmodule

// File: rtl/mac_product_stage.sv
module mac_product_stage
    import mac_slice_pkg::*;
#(
    parameter int W       = 18,
    parameter bit MID_REG = 1'b1,
    localparam int PW     = 2 * W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  mac_ctl_t            ctl_in,
    input  logic [LANES*W-1:0]  a_in,
    input  logic [LANES*W-1:0]  b_in,
    output mac_ctl_t            ctl_out,
    output logic [LANES*PW-1:0] prod_out
);

    logic [LANES*PW-1:0] prod_c;

    for (genvar k = 0; k < LANES; k++) begin : g_mul
        logic signed [W:0]    ea;
        logic signed [W:0]    eb;
        logic signed [PW-1:0] p;
        assign ea = {ctl_in.sgn & a_in[k*W+W-1], a_in[k*W +: W]};
        assign eb = {ctl_in.sgn & b_in[k*W+W-1], b_in[k*W +: W]};
        assign p  = ea * eb;
        assign prod_c[k*PW +: PW] = p;

        AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst)
            (ctl_in.vld && a_in[k*W +: W] == '0) |-> (p == '0)); // R2
        AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
            (ctl_in.vld && !ctl_in.sgn) |-> !p[PW-1]); // R3
    end

    if (MID_REG) begin : g_reg
        mac_ctl_t            ctl_q;
        logic [LANES*PW-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q  <= '0;
                prod_q <= '0;
            end else begin
                ctl_q  <= ctl_in;
                prod_q <= prod_c;
            end
        end
        assign ctl_out  = ctl_q;
        assign prod_out = prod_q;
    end else begin : g_pass
        assign ctl_out  = ctl_in;
        assign prod_out = prod_c;
    end

endmodule

// File: rtl/mac_combine_stage.sv
module mac_combine_stage
    import mac_slice_pkg::*;
#(
    parameter int W        = 18,
    parameter bit OUT_REG  = 1'b1,
    localparam int PW      = 2 * W + 2,
    localparam int ACC_W   = 2 * W + 16
) (
    input  logic                clk,
    input  logic                rst,
    input  mac_ctl_t            ctl_in,
    input  logic [LANES*PW-1:0] prod_in,
    output logic [ACC_W-1:0]    result,
    output logic                out_valid
);

    logic signed [ACC_W-1:0] ext_p [LANES];
    logic signed [ACC_W-1:0] pair_lo;
    logic signed [ACC_W-1:0] pair_hi;
    logic signed [ACC_W-1:0] comb_val;
    logic signed [ACC_W-1:0] acc_q;

    for (genvar k = 0; k < LANES; k++) begin : g_ext
        assign ext_p[k] = {{(ACC_W-PW){prod_in[k*PW+PW-1]}}, prod_in[k*PW +: PW]};
    end

    assign pair_lo = ctl_in.sub ? (ext_p[0] - ext_p[1]) : (ext_p[0] + ext_p[1]);
    assign pair_hi = ctl_in.sub ? (ext_p[2] - ext_p[3]) : (ext_p[2] + ext_p[3]);

    always_comb begin
        unique case (ctl_in.mode)
            MD_MULT: comb_val = ext_p[0];
            MD_MAC:  comb_val = (ctl_in.clr ? '0 : acc_q) + ext_p[0];
            MD_PAIR: comb_val = pair_lo;
            MD_QUAD: comb_val = pair_lo + pair_hi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctl_in.vld && ctl_in.mode == MD_MAC) begin
            acc_q <= comb_val;
        end
    end

    if (OUT_REG) begin : g_reg
        logic [ACC_W-1:0] res_q;
        logic             vld_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                res_q <= comb_val;
                vld_q <= ctl_in.vld;
            end
        end
        assign result    = res_q;
        assign out_valid = vld_q;
    end else begin : g_pass
        assign result    = comb_val;
        assign out_valid = ctl_in.vld;
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ctl_in.vld && ctl_in.mode == MD_MAC) |=> $stable(acc_q)); // R8
    AST_CLR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && ctl_in.mode == MD_MAC && ctl_in.clr) |=> (acc_q == $past(ext_p[0]))); // R7

endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter int W       = 18,
    parameter bit IN_REG  = 1'b1,
    parameter bit MID_REG = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              is_signed,
    input  logic              sub_en,
    input  logic              acc_clr,
    input  logic              shift_sel,
    input  logic [W-1:0]      shift_in,
    input  logic [4*W-1:0]    a_par,
    input  logic [4*W-1:0]    b_par,
    output logic [2*W+15:0]   result,
    output logic              out_valid,
    output logic [W-1:0]      shift_out
);

    localparam int PW = 2 * W + 2;

    if (!(W == 9 || W == 18 || W == 36)) begin : g_bad_width
        $error("mac_slice: W must be 9, 18 or 36");
    end

    mac_ctl_t            ctl_s0, ctl_s1, ctl_s2;
    logic [LANES*W-1:0]  a_s1, b_s1;
    logic [LANES*PW-1:0] prod_s2;

    assign ctl_s0 = '{vld: in_valid, mode: mac_mode_e'(mode), sgn: is_signed,
                      sub: sub_en, clr: acc_clr};

    mac_operand_stage #(.W(W), .IN_REG(IN_REG)) u_operand (
        .clk       (clk),
        .rst       (rst),
        .ctl_in    (ctl_s0),
        .shift_sel (shift_sel),
        .shift_in  (shift_in),
        .a_par     (a_par),
        .b_par     (b_par),
        .ctl_out   (ctl_s1),
        .a_out     (a_s1),
        .b_out     (b_s1),
        .shift_out (shift_out)
    );

    mac_product_stage #(.W(W), .MID_REG(MID_REG)) u_product (
        .clk      (clk),
        .rst      (rst),
        .ctl_in   (ctl_s1),
        .a_in     (a_s1),
        .b_in     (b_s1),
        .ctl_out  (ctl_s2),
        .prod_out (prod_s2)
    );

    mac_combine_stage #(.W(W), .OUT_REG(OUT_REG)) u_combine (
        .clk       (clk),
        .rst       (rst),
        .ctl_in    (ctl_s2),
        .prod_in   (prod_s2),
        .result    (result),
        .out_valid (out_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (shift_out == '0)); // R1

endmodule

// File: tb/mac_slice_tb.sv
`timescale 1ns/1ps
module mac_slice_tb;

    localparam int W     = 18;
    localparam int ACC_W = 2 * W + 16;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             is_signed = 1'b0, sub_en = 1'b0, acc_clr = 1'b0, shift_sel = 1'b0;
    logic [W-1:0]     shift_in = '0;
    logic [4*W-1:0]   a_par = '0, b_par = '0;
    logic [ACC_W-1:0] result, result_c;
    logic             out_valid, out_valid_c;
    logic [W-1:0]     shift_out, shift_out_c;

    int checks = 0;
    int bad    = 0;
    logic [63:0]    m_acc;
    logic [4*W-1:0] m_chain;

    always #2.5 clk = ~clk;

    mac_slice #(.W(W), .IN_REG(1), .MID_REG(1), .OUT_REG(1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .is_signed(is_signed),
        .sub_en(sub_en), .acc_clr(acc_clr), .shift_sel(shift_sel), .shift_in(shift_in),
        .a_par(a_par), .b_par(b_par), .result(result), .out_valid(out_valid),
        .shift_out(shift_out));

    mac_slice #(.W(W), .IN_REG(0), .MID_REG(0), .OUT_REG(0)) u_dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .is_signed(is_signed),
        .sub_en(sub_en), .acc_clr(acc_clr), .shift_sel(shift_sel), .shift_in(shift_in),
        .a_par(a_par), .b_par(b_par), .result(result_c), .out_valid(out_valid_c),
        .shift_out(shift_out_c));

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic signed [63:0] ext(input logic [W-1:0] v, input bit sg);
        return sg ? {{(64-W){v[W-1]}}, v} : {{(64-W){1'b0}}, v};
    endfunction

    task automatic calc(input int md, input bit sg, input bit sb, input bit cl, input bit ss,
                        input logic [W-1:0] sin, input logic [4*W-1:0] av, input logic [4*W-1:0] bv,
                        output logic [63:0] e);
        logic [4*W-1:0]    ea;
        logic signed [63:0] p [4];
        ea = ss ? {m_chain[3*W-1:0], sin} : av;
        m_chain = ea;
        for (int k = 0; k < 4; k++) p[k] = ext(ea[k*W +: W], sg) * ext(bv[k*W +: W], sg);
        case (md)
            0: e = p[0];
            1: begin e = (cl ? 64'd0 : m_acc) + p[0]; m_acc = e; end
            2: e = sb ? p[0] - p[1] : p[0] + p[1];
            default: e = (sb ? p[0] - p[1] : p[0] + p[1]) + (sb ? p[2] - p[3] : p[2] + p[3]);
        endcase
    endtask

    task automatic drive(input int md, input bit sg, input bit sb, input bit cl, input bit ss,
                         input logic [W-1:0] sin, input logic [4*W-1:0] av, input logic [4*W-1:0] bv);
        in_valid = 1'b1; mode = md[1:0]; is_signed = sg; sub_en = sb; acc_clr = cl;
        shift_sel = ss; shift_in = sin; a_par = av; b_par = bv;
    endtask

    // one sample, checked on both the piped and the combinational instance
    task automatic issue(input int md, input bit sg, input bit sb, input bit cl, input bit ss,
                         input logic [W-1:0] sin, input logic [4*W-1:0] av, input logic [4*W-1:0] bv,
                         input string rq);
        logic [63:0] e;
        @(negedge clk);
        calc(md, sg, sb, cl, ss, sin, av, bv, e);
        drive(md, sg, sb, cl, ss, sin, av, bv);
        #1;
        check(out_valid_c === 1'b1, {rq, " R9 comb valid"}, 64'(out_valid_c), 64'd1);
        check(result_c === e[ACC_W-1:0], {rq, " comb"}, 64'(result_c), 64'(e[ACC_W-1:0]));
        @(negedge clk);
        in_valid = 1'b0;
        check(shift_out === m_chain[4*W-1 -: W], "R10 shift_out", 64'(shift_out), 64'(m_chain[4*W-1 -: W]));
        @(negedge clk);
        check(out_valid === 1'b0, "R9 early valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_valid === 1'b1, "R9 valid at latency", 64'(out_valid), 64'd1);
        check(result === e[ACC_W-1:0], rq, 64'(result), 64'(e[ACC_W-1:0]));
    endtask

    task automatic t_reset();
        check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(shift_out === '0, "R1 shift_out", 64'(shift_out), 64'd0);
        issue(1, 1, 0, 0, 0, '0, {54'd0, 18'd11}, {54'd0, 18'd3}, "R1 acc starts at zero");
    endtask

    task automatic t_mult();
        issue(0, 1, 0, 0, 0, '0, {54'd0, 18'h3FFFB}, {54'd0, 18'd7}, "R2 signed -5*7");
        issue(0, 0, 0, 0, 0, '0, {54'd0, 18'h3FFFF}, {54'd0, 18'h3FFFF}, "R3 unsigned max*max");
        issue(0, 1, 0, 0, 0, '0, {54'd0, 18'h20000}, {54'd0, 18'h20000}, "R3 signed minneg*minneg");
        issue(0, 1, 0, 0, 0, '0, {54'd0, 18'h20000}, {54'd0, 18'h1FFFF}, "R3 signed minneg*maxpos");
        issue(0, 1, 0, 0, 0, '0, {54'd0, 18'd0}, {54'd0, 18'h20000}, "R2 zero operand");
    endtask

    task automatic t_pair();
        issue(2, 1, 0, 0, 0, '0, {36'd0, 18'h3FFFE, 18'd100}, {36'd0, 18'd9, 18'd4}, "R4 signed add");
        issue(2, 1, 1, 0, 0, '0, {36'd0, 18'h20000, 18'd5}, {36'd0, 18'h20000, 18'd6}, "R4 signed sub");
        issue(2, 0, 1, 0, 0, '0, {36'd0, 18'h3FFFF, 18'd1}, {36'd0, 18'h3FFFF, 18'd1}, "R4 unsigned sub negative");
    endtask

    task automatic t_quad();
        issue(3, 1, 0, 0, 0, '0, {18'h20000, 18'h20000, 18'h20000, 18'h20000},
              {18'h20000, 18'h20000, 18'h20000, 18'h20000}, "R5 signed add all minneg");
        issue(3, 0, 1, 0, 0, '0, {18'd7, 18'h3FFFF, 18'd3, 18'h3FFFF},
              {18'd2, 18'h3FFFF, 18'd5, 18'h3FFFF}, "R5 unsigned sub");
    endtask

    task automatic t_mac();
        issue(1, 1, 0, 1, 0, '0, {54'd0, 18'h3FFF0}, {54'd0, 18'd25}, "R7 clear loads product");
        issue(1, 1, 0, 0, 0, '0, {54'd0, 18'd40}, {54'd0, 18'd40}, "R6 accumulate");
        issue(0, 1, 0, 0, 0, '0, {54'd0, 18'd99}, {54'd0, 18'd99}, "R8 other mode");
        repeat (5) @(negedge clk);
        issue(1, 1, 0, 0, 0, '0, {54'd0, 18'd1}, {54'd0, 18'd1}, "R8 hold across idle and other mode");
    endtask

    task automatic t_shift();
        issue(3, 0, 0, 0, 0, '0, {18'd40, 18'd30, 18'd20, 18'd10}, {4{18'd1}}, "R10 parallel load");
        issue(3, 0, 0, 0, 1, 18'd5, '0, {4{18'd1}}, "R10 shift one");
        issue(3, 0, 0, 0, 1, 18'd6, '0, {4{18'd1}}, "R10 shift two");
        repeat (3) @(negedge clk);
        check(shift_out === m_chain[4*W-1 -: W], "R10 shift_out holds idle", 64'(shift_out),
              64'(m_chain[4*W-1 -: W]));
    endtask

    // back-to-back samples; kind 0 mixed settings, kind 1 long MAC run of max products
    task automatic t_stream(input int kind, input int n);
        logic [63:0] exq [0:39];
        for (int i = 0; i < n + LAT; i++) begin
            @(negedge clk);
            if (i < n) begin
                int md; bit sg, sb, cl;
                logic [4*W-1:0] av, bv;
                logic [W-1:0]   sin;
                if (kind == 0) begin
                    md = i % 4; sg = i[0] ^ i[2]; sb = i[1]; cl = (i % 5 == 0);
                    av = {$urandom, $urandom, $urandom}; bv = {$urandom, $urandom, $urandom};
                end else begin
                    md = 1; sg = 0; sb = 0; cl = (i == 0);
                    av = {4{18'h3FFFF}}; bv = {4{18'h3FFFF}};
                end
                sin = 18'($urandom);
                calc(md, sg, sb, cl, 1'b0, sin, av, bv, exq[i]);
                drive(md, sg, sb, cl, 1'b0, sin, av, bv);
                #1;
                check(result_c === exq[i][ACC_W-1:0], kind == 0 ? "R11 comb stream" : "R6 comb long run",
                      64'(result_c), 64'(exq[i][ACC_W-1:0]));
            end else begin
                in_valid = 1'b0;
                #1;
            end
            if (i >= LAT) begin
                check(out_valid === 1'b1, "R9 stream valid", 64'(out_valid), 64'd1);
                check(result === exq[i-LAT][ACC_W-1:0], kind == 0 ? "R11 stream" : "R6 long run past product range",
                      64'(result), 64'(exq[i-LAT][ACC_W-1:0]));
            end
        end
    endtask

    initial begin
        m_acc = '0;
        m_chain = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mult();
        t_pair();
        t_quad();
        t_mac();
        t_shift();
        t_stream(0, 32);
        t_stream(1, 24);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule